// File: doc/BRIEF.md
# Virtual Page Translator with LRU Frame Replacement

This block translates 20-bit virtual addresses into 18-bit physical addresses through a single-level page table. The page size is 16 KB, so the low 14 bits of an address pass through unchanged. The upper 6 bits choose one of 64 table entries. Each entry holds a valid flag and a 4-bit frame number, which selects one of 16 physical frames. A request is accepted over a valid/ready handshake and answered one cycle later. The answer is either a physical address or a fault indication.

When a lookup misses, the block handles the fault itself. It picks the least recently used physical frame as the victim. It clears the table entry of the virtual page that owned that frame, and it reports the frame and the evicted page to the surrounding system, which performs the data transfer. When the transfer is finished, the system pulses `load_done`. The block then maps the faulting page onto the freed frame and accepts requests again. A preload port lets the system install mappings directly while the block is idle.

Top module: `vpage_xlate`

## Requirements
- R1: A request is accepted in a cycle where `req_valid` and `req_ready` are both high. In the next cycle `rsp_valid` is high for exactly one cycle. For a valid entry, `rsp_fault` is 0 and `rsp_pa` is {frame number (4 bits), `req_va[13:0]`}, where the entry is selected by `req_va[19:14]`.
- R2: A request whose entry is invalid answers with `rsp_fault` = 1 and `rsp_pa` = 0.
- R3: Reset clears every entry's valid flag, so any lookup after reset faults.
- R4: The victim is the least recently used frame. After reset the usage order runs from frame 15 (oldest) to frame 0 (newest). A hit, a preload or an install makes its frame the newest.
- R5: From the second cycle after a faulting acceptance until install, `vic_valid` is high and holds steady values. `vic_ppn` is the victim frame. `vic_owned` shows whether a page held that frame, and `vic_vpn` is that page.
- R6: The page that owned the victim frame loses its mapping, so a later lookup of it faults.
- R7: A `load_done` pulse while `vic_valid` is high maps the faulting page onto the victim frame. A retried request for that page then hits, with PA {victim frame, offset}.
- R8: `req_ready` is low from the faulting acceptance until the cycle after `load_done`. A request held during that time is not answered. A `load_done` pulse while no fault is pending has no effect.
- R9: While idle, `pre_we` writes entry `pre_vpn` as valid with frame `pre_ppn`, and `req_ready` is low in that cycle. A `pre_we` while a fault is pending is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request present |
| req_va | input | 20 | Virtual address |
| req_ready | output | 1 | Request can be accepted |
| rsp_valid | output | 1 | Answer present (one cycle) |
| rsp_fault | output | 1 | Answer is a page fault |
| rsp_pa | output | 18 | Physical address (0 on fault) |
| vic_valid | output | 1 | Fault pending, victim fields valid |
| vic_ppn | output | 4 | Victim frame to be refilled |
| vic_vpn | output | 6 | Page that held the victim frame |
| vic_owned | output | 1 | The victim frame had an owner |
| load_done | input | 1 | Transfer into the victim frame finished |
| pre_we | input | 1 | Preload write strobe |
| pre_vpn | input | 6 | Preload page number |
| pre_ppn | input | 4 | Preload frame number |

## Verification
The checks assume that each preloaded page and each preloaded frame is used once only between resets, so the record of which page owns each frame stays consistent with the table. They also assume that `load_done` is pulsed only in answer to a reported victim. The stimulus preloads distinct page/frame pairs after each reset, pulses `load_done` only once per fault (apart from one deliberate idle pulse), and chooses the order of preloads and hits so that both a free victim frame and an owned victim frame appear.

// File: rtl/pgx_pkg.sv
package pgx_pkg;
    localparam int PG_VA_W  = 20;
    localparam int PG_OFF_W = 14;
    localparam int PG_PPN_W = 4;
    localparam int PG_VPN_W = PG_VA_W - PG_OFF_W;

    typedef enum logic [1:0] {
        XL_IDLE  = 2'd0,
        XL_EVICT = 2'd1,
        XL_WAIT  = 2'd2
    } xl_state_e;
endpackage

// File: rtl/pgx_table.sv
module pgx_table #(
    parameter int VPN_W = 6,
    parameter int PPN_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [VPN_W-1:0] rd_vpn,
    output logic             rd_valid,
    output logic [PPN_W-1:0] rd_ppn,
    input  logic [PPN_W-1:0] own_frame,
    output logic             own_valid,
    output logic [VPN_W-1:0] own_vpn,
    input  logic             wr_en,
    input  logic [VPN_W-1:0] wr_vpn,
    input  logic [PPN_W-1:0] wr_ppn,
    input  logic             kill_en,
    input  logic [PPN_W-1:0] kill_frame
);
    localparam int ENTRIES = 1 << VPN_W;
    localparam int FRAMES  = 1 << PPN_W;

    logic             ent_vld [ENTRIES];
    logic [PPN_W-1:0] ent_ppn [ENTRIES];
    logic             frm_vld [FRAMES];
    logic [VPN_W-1:0] frm_vpn [FRAMES];

    assign rd_valid  = ent_vld[rd_vpn];
    assign rd_ppn    = ent_ppn[rd_vpn];
    assign own_valid = frm_vld[own_frame];
    assign own_vpn   = frm_vpn[own_frame];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ENTRIES; i++) ent_vld[i] <= 1'b0;
            for (int j = 0; j < FRAMES; j++)  frm_vld[j] <= 1'b0;
        end else if (wr_en) begin
            ent_vld[wr_vpn] <= 1'b1;
            frm_vld[wr_ppn] <= 1'b1;
        end else if (kill_en) begin
            if (frm_vld[kill_frame]) ent_vld[frm_vpn[kill_frame]] <= 1'b0;
            frm_vld[kill_frame] <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            ent_ppn[wr_vpn] <= wr_ppn;
            frm_vpn[wr_ppn] <= wr_vpn;
        end
    end
endmodule

// File: rtl/pgx_lru.sv
module pgx_lru #(
    parameter int PPN_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              touch_en,
    input  logic [PPN_W-1:0]  touch_frame,
    output logic [PPN_W-1:0]  victim,
    output logic [(1<<PPN_W)-1:0] oldest_hot
);
    localparam int FRAMES = 1 << PPN_W;
    localparam logic [PPN_W-1:0] AGE_MAX = PPN_W'(FRAMES - 1);

    logic [PPN_W-1:0] age [FRAMES];
    logic [PPN_W-1:0] touched_age;

    assign touched_age = age[touch_frame];

    generate
        for (genvar g = 0; g < FRAMES; g++) begin : g_age
            assign oldest_hot[g] = (age[g] == AGE_MAX);
            always_ff @(posedge clk) begin
                if (rst) begin
                    age[g] <= PPN_W'(g);
                end else if (touch_en) begin
                    if (touch_frame == PPN_W'(g))
                        age[g] <= '0;
                    else if (age[g] < touched_age)
                        age[g] <= age[g] + 1'b1;
                end
            end
        end
    endgenerate

    always_comb begin
        victim = '0;
        for (int i = 0; i < FRAMES; i++) begin
            if (oldest_hot[i]) victim = PPN_W'(i);
        end
    end
endmodule

// File: rtl/pgx_ctrl.sv
module pgx_ctrl
    import pgx_pkg::*;
#(
    parameter int VA_W  = 20,
    parameter int OFF_W = 14,
    parameter int PPN_W = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   req_valid,
    input  logic [VA_W-1:0]        req_va,
    output logic                   req_ready,
    output logic                   rsp_valid,
    output logic                   rsp_fault,
    output logic [OFF_W+PPN_W-1:0] rsp_pa,
    output logic                   vic_valid,
    output logic [PPN_W-1:0]       vic_ppn,
    output logic [VA_W-OFF_W-1:0]  vic_vpn,
    output logic                   vic_owned,
    input  logic                   load_done,
    input  logic                   pre_we,
    input  logic [VA_W-OFF_W-1:0]  pre_vpn,
    input  logic [PPN_W-1:0]       pre_ppn,
    // table side
    output logic [VA_W-OFF_W-1:0]  tb_rd_vpn,
    input  logic                   tb_rd_valid,
    input  logic [PPN_W-1:0]       tb_rd_ppn,
    input  logic                   tb_own_valid,
    input  logic [VA_W-OFF_W-1:0]  tb_own_vpn,
    output logic                   tb_wr_en,
    output logic [VA_W-OFF_W-1:0]  tb_wr_vpn,
    output logic [PPN_W-1:0]       tb_wr_ppn,
    output logic                   tb_kill_en,
    // replacement side
    input  logic [PPN_W-1:0]       lru_victim,
    output logic                   lru_touch_en,
    output logic [PPN_W-1:0]       lru_touch_frame
);
    localparam int VPN_W = VA_W - OFF_W;
    localparam int PA_W  = OFF_W + PPN_W;

    typedef struct packed {
        logic [VPN_W-1:0] vpn;
        logic [PPN_W-1:0] frame;
        logic [VPN_W-1:0] owner;
        logic             owned;
    } fault_rec_t;

    xl_state_e  state;
    fault_rec_t frec;
    logic       accept;
    logic       hit;
    logic       install;

    assign req_ready = (state == XL_IDLE) && !pre_we;
    assign accept    = req_valid && req_ready;
    assign tb_rd_vpn = req_va[VA_W-1:OFF_W];
    assign hit       = tb_rd_valid;
    assign install   = (state == XL_WAIT) && load_done;

    assign tb_wr_en  = ((state == XL_IDLE) && pre_we) || install;
    assign tb_wr_vpn = install ? frec.vpn : pre_vpn;
    assign tb_wr_ppn = install ? frec.frame : pre_ppn;
    assign tb_kill_en = (state == XL_EVICT);

    assign lru_touch_en    = (accept && hit) || tb_wr_en;
    assign lru_touch_frame = (accept && hit) ? tb_rd_ppn : tb_wr_ppn;

    assign vic_valid = (state == XL_WAIT);
    assign vic_ppn   = frec.frame;
    assign vic_vpn   = frec.owner;
    assign vic_owned = frec.owned;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= XL_IDLE;
            frec      <= '0;
            rsp_valid <= 1'b0;
            rsp_fault <= 1'b0;
            rsp_pa    <= '0;
        end else begin
            rsp_valid <= accept;
            rsp_fault <= accept && !hit;
            rsp_pa    <= (accept && hit) ? {tb_rd_ppn, req_va[OFF_W-1:0]} : PA_W'(0);
            unique case (state)
                XL_IDLE: begin
                    if (accept && !hit) begin
                        state      <= XL_EVICT;
                        frec.vpn   <= tb_rd_vpn;
                        frec.frame <= lru_victim;
                        frec.owner <= tb_own_vpn;
                        frec.owned <= tb_own_valid;
                    end
                end
                XL_EVICT: state <= XL_WAIT;
                XL_WAIT:  if (load_done) state <= XL_IDLE;
                default:  state <= XL_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/vpage_xlate.sv
module vpage_xlate #(
    parameter int VA_W  = pgx_pkg::PG_VA_W,
    parameter int OFF_W = pgx_pkg::PG_OFF_W,
    parameter int PPN_W = pgx_pkg::PG_PPN_W
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   req_valid,
    input  logic [VA_W-1:0]        req_va,
    output logic                   req_ready,
    output logic                   rsp_valid,
    output logic                   rsp_fault,
    output logic [OFF_W+PPN_W-1:0] rsp_pa,
    output logic                   vic_valid,
    output logic [PPN_W-1:0]       vic_ppn,
    output logic [VA_W-OFF_W-1:0]  vic_vpn,
    output logic                   vic_owned,
    input  logic                   load_done,
    input  logic                   pre_we,
    input  logic [VA_W-OFF_W-1:0]  pre_vpn,
    input  logic [PPN_W-1:0]       pre_ppn
);
    localparam int VPN_W  = VA_W - OFF_W;
    localparam int FRAMES = 1 << PPN_W;

    logic [VPN_W-1:0]  rd_vpn;
    logic              rd_valid;
    logic [PPN_W-1:0]  rd_ppn;
    logic              own_valid;
    logic [VPN_W-1:0]  own_vpn;
    logic              wr_en;
    logic [VPN_W-1:0]  wr_vpn;
    logic [PPN_W-1:0]  wr_ppn;
    logic              kill_en;
    logic [PPN_W-1:0]  lru_victim;
    logic              touch_en;
    logic [PPN_W-1:0]  touch_frame;
    logic [FRAMES-1:0] oldest_hot;

    pgx_table #(.VPN_W(VPN_W), .PPN_W(PPN_W)) u_table (
        .clk(clk), .rst(rst),
        .rd_vpn(rd_vpn), .rd_valid(rd_valid), .rd_ppn(rd_ppn),
        .own_frame(lru_victim), .own_valid(own_valid), .own_vpn(own_vpn),
        .wr_en(wr_en), .wr_vpn(wr_vpn), .wr_ppn(wr_ppn),
        .kill_en(kill_en), .kill_frame(vic_ppn)
    );

    pgx_lru #(.PPN_W(PPN_W)) u_lru (
        .clk(clk), .rst(rst),
        .touch_en(touch_en), .touch_frame(touch_frame),
        .victim(lru_victim), .oldest_hot(oldest_hot)
    );

    pgx_ctrl #(.VA_W(VA_W), .OFF_W(OFF_W), .PPN_W(PPN_W)) u_ctrl (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_va(req_va), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_pa(rsp_pa),
        .vic_valid(vic_valid), .vic_ppn(vic_ppn), .vic_vpn(vic_vpn),
        .vic_owned(vic_owned), .load_done(load_done),
        .pre_we(pre_we), .pre_vpn(pre_vpn), .pre_ppn(pre_ppn),
        .tb_rd_vpn(rd_vpn), .tb_rd_valid(rd_valid), .tb_rd_ppn(rd_ppn),
        .tb_own_valid(own_valid), .tb_own_vpn(own_vpn),
        .tb_wr_en(wr_en), .tb_wr_vpn(wr_vpn), .tb_wr_ppn(wr_ppn),
        .tb_kill_en(kill_en),
        .lru_victim(lru_victim), .lru_touch_en(touch_en),
        .lru_touch_frame(touch_frame)
    );
endmodule

// File: rtl/pgx_checker.sv
module pgx_checker #(
    parameter int VA_W  = 20,
    parameter int OFF_W = 14,
    parameter int PPN_W = 4
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   req_valid,
    input logic [VA_W-1:0]        req_va,
    input logic                   req_ready,
    input logic                   rsp_valid,
    input logic                   rsp_fault,
    input logic [OFF_W+PPN_W-1:0] rsp_pa,
    input logic                   vic_valid,
    input logic [PPN_W-1:0]       vic_ppn,
    input logic [VA_W-OFF_W-1:0]  vic_vpn,
    input logic                   load_done,
    input logic [(1<<PPN_W)-1:0]  oldest_hot
);
    p_rsp_follows_accept_r1: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(req_valid && req_ready));

    p_offset_kept_r1: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_fault) |-> (rsp_pa[OFF_W-1:0] == $past(req_va[OFF_W-1:0])));

    p_fault_zero_pa_r2: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_fault) |-> (rsp_pa == '0));

    p_single_oldest_r4: assert property (@(posedge clk) disable iff (rst)
        $countones(oldest_hot) == 1);

    p_fault_reports_victim_r5: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_fault) |=> vic_valid);

    p_victim_steady_r5: assert property (@(posedge clk) disable iff (rst)
        (vic_valid && !$rose(vic_valid)) |-> ($stable(vic_ppn) && $stable(vic_vpn)));

    p_release_on_load_r7: assert property (@(posedge clk) disable iff (rst)
        (vic_valid && load_done) |=> !vic_valid);

    p_stall_while_pending_r8: assert property (@(posedge clk) disable iff (rst)
        vic_valid |-> !req_ready);
endmodule

bind vpage_xlate pgx_checker #(.VA_W(VA_W), .OFF_W(OFF_W), .PPN_W(PPN_W)) u_pgx_checker (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_va(req_va),
    .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
    .rsp_pa(rsp_pa), .vic_valid(vic_valid), .vic_ppn(vic_ppn),
    .vic_vpn(vic_vpn), .load_done(load_done), .oldest_hot(oldest_hot)
);

// File: tb/test_vpage_xlate.sv
module test_vpage_xlate;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [19:0] req_va = '0;
    logic        req_ready;
    logic        rsp_valid;
    logic        rsp_fault;
    logic [17:0] rsp_pa;
    logic        vic_valid;
    logic [3:0]  vic_ppn;
    logic [5:0]  vic_vpn;
    logic        vic_owned;
    logic        load_done = 1'b0;
    logic        pre_we = 1'b0;
    logic [5:0]  pre_vpn = '0;
    logic [3:0]  pre_ppn = '0;

    int n_chk  = 0;
    int n_fail = 0;

    // {virtual address, expected physical address} after the phase-1 preloads
    localparam logic [37:0] HIT_VEC [0:3] = '{
        {20'h08CAA, 18'h08CAA},
        {20'h1BFFF, 18'h27FFF},
        {20'hFC000, 18'h3C000},
        {20'h01234, 18'h01234}
    };

    always #(CLK_PERIOD/2) clk = ~clk;

    vpage_xlate i_vpage_xlate (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_va(req_va),
        .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
        .rsp_pa(rsp_pa), .vic_valid(vic_valid), .vic_ppn(vic_ppn),
        .vic_vpn(vic_vpn), .vic_owned(vic_owned), .load_done(load_done),
        .pre_we(pre_we), .pre_vpn(pre_vpn), .pre_ppn(pre_ppn)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic preload(input logic [5:0] vpn, input logic [3:0] ppn);
        @(negedge clk);
        pre_we = 1'b1; pre_vpn = vpn; pre_ppn = ppn;
        @(negedge clk);
        pre_we = 1'b0;
    endtask

    // ends at the negedge where the answer is visible
    task automatic lookup(input logic [19:0] va, input string tag,
                          input logic exp_fault, input logic [17:0] exp_pa);
        @(negedge clk);
        req_valid = 1'b1; req_va = va;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        check({tag, " rsp_valid"}, 32'(rsp_valid), 32'd1);
        check({tag, " rsp_fault"}, 32'(rsp_fault), 32'(exp_fault));
        check({tag, " rsp_pa"}, 32'(rsp_pa), 32'(exp_pa));
    endtask

    // called right after a faulting lookup
    task automatic expect_victim(input string tag, input logic [3:0] frame,
                                 input logic owned, input logic [5:0] owner);
        @(negedge clk);
        check({tag, " vic_valid"}, 32'(vic_valid), 32'd1);
        check({tag, " vic_ppn"}, 32'(vic_ppn), 32'(frame));
        check({tag, " vic_owned"}, 32'(vic_owned), 32'(owned));
        if (owned) check({tag, " vic_vpn"}, 32'(vic_vpn), 32'(owner));
        check({tag, " req_ready low"}, 32'(req_ready), 32'd0);
    endtask

    task automatic finish_load();
        @(negedge clk);
        load_done = 1'b1;
        @(posedge clk);
        @(negedge clk);
        load_done = 1'b0;
        check("R8 ready after load_done", 32'(req_ready), 32'd1);
        check("R7 vic_valid cleared", 32'(vic_valid), 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        // Phase 0: reset state, R3 and the reset usage order of R4
        do_reset();
        check("R3 reset req_ready", 32'(req_ready), 32'd1);
        check("R3 reset rsp_valid", 32'(rsp_valid), 32'd0);
        check("R5 reset vic_valid", 32'(vic_valid), 32'd0);
        lookup(20'h08CAA, "R3 lookup after reset", 1'b1, 18'h0);
        expect_victim("R4 reset oldest frame", 4'd15, 1'b0, 6'd0);
        finish_load();

        // Phase 1: preloads and hit table (R9, R1)
        do_reset();
        preload(6'd2, 4'd2);
        preload(6'd6, 4'd9);
        preload(6'd63, 4'd15);
        preload(6'd0, 4'd0);
        for (int k = 0; k < 4; k++) begin
            lookup(HIT_VEC[k][37:18], "R1 R9 table hit", 1'b0, HIT_VEC[k][17:0]);
        end

        // R8: load_done while idle does nothing
        @(negedge clk);
        load_done = 1'b1;
        @(negedge clk);
        load_done = 1'b0;
        check("R8 idle load_done vic_valid", 32'(vic_valid), 32'd0);
        check("R8 idle load_done ready", 32'(req_ready), 32'd1);
        lookup(20'h08CAA, "R8 idle load_done mapping kept", 1'b0, 18'h08CAA);

        // R2/R4/R5: miss on page 40, oldest frame is 14 and free
        lookup(20'hA0055, "R2 miss", 1'b1, 18'h0);
        expect_victim("R4 R5 first victim", 4'd14, 1'b0, 6'd0);

        // R8 stall and R9 ignored preload while pending
        @(negedge clk);
        req_valid = 1'b1; req_va = 20'h08CAA;
        pre_we = 1'b1; pre_vpn = 6'd5; pre_ppn = 4'd4;
        @(negedge clk);
        pre_we = 1'b0;
        check("R8 held request not answered", 32'(rsp_valid), 32'd0);
        check("R8 ready low while pending", 32'(req_ready), 32'd0);
        @(negedge clk);
        check("R8 held request still not answered", 32'(rsp_valid), 32'd0);
        req_valid = 1'b0;
        finish_load();

        lookup(20'hA0055, "R7 retry hits", 1'b0, 18'h38055);
        lookup(20'h14000, "R9 preload during fault ignored", 1'b1, 18'h0);
        expect_victim("R4 next victim", 4'd13, 1'b0, 6'd0);
        finish_load();

        // Phase 2: all frames owned, eviction of an owner (R4, R5, R6)
        do_reset();
        for (int k = 0; k < 16; k++) begin
            preload(6'(k + 16), 4'(k));
        end
        lookup(20'h40000, "R1 hit frame 0", 1'b0, 18'h00000);
        lookup(20'hC8007, "R2 miss page 50", 1'b1, 18'h0);
        expect_victim("R4 R5 owned victim", 4'd1, 1'b1, 6'd17);
        finish_load();
        lookup(20'hC8007, "R7 retry page 50", 1'b0, 18'h04007);
        lookup(20'h44000, "R6 evicted page faults", 1'b1, 18'h0);
        expect_victim("R4 R5 following victim", 4'd2, 1'b1, 6'd18);
        finish_load();

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule